// File: doc/BRIEF.md
# Reset Cause Tracking and Start-up Delay Sequencer

This block records which kind of reset the device last went through and keeps the processor core held in reset until a start-up delay has elapsed. The delay length depends on what caused the reset and on whether the main oscillator is a crystal-type source. Crystal-type sources need a count of oscillator cycles to settle; non-crystal sources do not. A power-up timer, counted on a slow always-running time base, can be added in front of that count for power and supply-dip resets.

Software sees an 8-bit status/control register. Two sticky flags let firmware tell a power-on reset from a brown-out reset. One bit selects the fast or low-power rate of the internal oscillator. One bit is a software watchdog enable, which is ORed with a fixed configuration enable. The slow time base comes in as a one-cycle tick synchronous to `clk`. The synchronous active-low `rst_n` acts exactly like a power-on reset event.

Top module: `rst_cause_sequencer`

## Requirements
- R1: A power-on event (`por_evt`, or `rst_n` low) leaves the register reading 0x09: bit 1 (power-on flag) = 0, bit 0 (brown-out flag) = 1, bit 3 (fast rate) = 1, bit 4 (software watchdog enable) = 0.
- R2: A brown-out event while `bod_en` = 1, with no power-on event, clears bit 0, keeps bit 1, and returns bits 3 and 4 to 1 and 0. While `bod_en` = 0, `bor_evt` has no effect on the register or on `core_hold`.
- R3: A watchdog reset keeps bits 0 and 1 and returns bits 3 and 4 to 1 and 0. A wake event leaves the whole register unchanged.
- R4: A write (`wr_en`) loads bits 0, 1, 3 and 4 from `wr_data`. Bits 2, 5, 6 and 7 always read 0. A reset event in the same cycle takes precedence over the write.
- R5: `osc_fast` equals register bit 3 (1 = fast rate, 0 = low-power rate). `wdt_run` is 1 when `wdt_fuse` is 1 or bit 4 is 1.
- R6: In crystal mode (`xtal_mode` = 1), a power-on or brown-out event holds the core for the power-up period followed by OST_CYCLES clock cycles when `pwrt_en` = 1, and for OST_CYCLES cycles only when `pwrt_en` = 0.
- R7: In non-crystal mode, a power-on or brown-out event holds the core for the power-up period when `pwrt_en` = 1, and does not hold it at all when `pwrt_en` = 0.
- R8: A watchdog reset or a wake event holds the core for OST_CYCLES cycles in crystal mode and not at all in non-crystal mode. The power-up timer is never used for these events. A wake event is ignored while `core_hold` is 1.
- R9: `core_hold` rises in the cycle after the event and stays high for exactly the delay. The power-up period ends on the PWRT_TICKS-th `slow_tick` sampled after the event. Event priority is power-on, then brown-out, then watchdog, then wake. A reset event during a delay restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-on |
| slow_tick | input | 1 | One-cycle pulse of the slow power-up time base |
| por_evt | input | 1 | Power-on reset event |
| bor_evt | input | 1 | Brown-out reset event |
| bod_en | input | 1 | Brown-out detection enabled |
| wdt_evt | input | 1 | Watchdog reset event |
| wake_evt | input | 1 | Wake-from-sleep event |
| xtal_mode | input | 1 | 1 = crystal-type oscillator source |
| pwrt_en | input | 1 | Power-up timer enabled |
| wdt_fuse | input | 1 | Fixed configuration watchdog enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| status | output | REG_W | Register contents |
| core_hold | output | 1 | Holds the core in reset |
| osc_fast | output | 1 | Internal oscillator rate select |
| wdt_run | output | 1 | Watchdog enabled |

## Verification
The assertions check on every cycle the flag rules of each reset type: the values after a power-on event, the brown-out flag clearing while the power-on flag is kept, both flags surviving a watchdog reset, and the reserved bits staying zero. They also check that a non-crystal wake never holds the core. Only the bench scenarios can show the length of each delay. It sweeps every cause against both oscillator modes and both timer settings, with the tick phase taken into account, and also covers restart, ignored wakes, priority and write collisions.

// File: rtl/rst_seq_pkg.sv
// Shared types for the reset cause sequencer.
// Assumes an 8-bit register view; bit positions are fixed by software use.
package rst_seq_pkg;
    typedef enum logic [1:0] {SQ_START, SQ_PWRT, SQ_OST, SQ_RUN} seq_state_t;
    typedef enum logic [2:0] {CZ_NONE, CZ_POR, CZ_BOR, CZ_WDT, CZ_WAKE} cause_t;
    localparam int BIT_BOR  = 0;
    localparam int BIT_POR  = 1;
    localparam int BIT_FAST = 3;
    localparam int BIT_WSW  = 4;
endpackage

// File: rtl/rst_cause_arb.sv
// Picks the single reset cause acted on this cycle.
// Priority: power-on, brown-out (only when detection is on), watchdog, wake.
// Wake is dropped while the core is still held.
module rst_cause_arb
    import rst_seq_pkg::*;
(
    input  logic   por_evt,
    input  logic   bor_evt,
    input  logic   bod_en,
    input  logic   wdt_evt,
    input  logic   wake_evt,
    input  logic   core_hold,
    output cause_t cause
);
    // Fixed-priority selection of the winning event.
    always_comb begin
        if (por_evt)                     cause = CZ_POR;
        else if (bor_evt && bod_en)      cause = CZ_BOR;
        else if (wdt_evt)                cause = CZ_WDT;
        else if (wake_evt && !core_hold) cause = CZ_WAKE;
        else                             cause = CZ_NONE;
    end
endmodule

// File: rtl/rst_span_counter.sv
// Up-counter that reports when it reaches a terminal value while counting.
// It wraps to zero on done or clear. Assumes limit fits in W bits.
module rst_span_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    // Terminal detect on a counted step.
    assign done = inc && (cnt == limit);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clr || done)   cnt <= '0;
        else if (inc)           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rst_status_reg.sv
// Status/control register: sticky reset flags plus oscillator-rate and
// software watchdog bits. A reset cause always beats a software write.
module rst_status_reg
    import rst_seq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cause_t           cause,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] status
);
    logic bor_f, por_f, fast_b, wsw_b;

    // Flag and control updates per reset cause, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bor_f <= 1'b1; por_f <= 1'b0; fast_b <= 1'b1; wsw_b <= 1'b0;
        end else begin
            case (cause)
                CZ_POR: begin
                    bor_f <= 1'b1; por_f <= 1'b0; fast_b <= 1'b1; wsw_b <= 1'b0;
                end
                CZ_BOR: begin
                    bor_f <= 1'b0; fast_b <= 1'b1; wsw_b <= 1'b0;
                end
                CZ_WDT: begin
                    fast_b <= 1'b1; wsw_b <= 1'b0;
                end
                default: begin
                    if (wr_en) begin
                        bor_f  <= wr_data[BIT_BOR];
                        por_f  <= wr_data[BIT_POR];
                        fast_b <= wr_data[BIT_FAST];
                        wsw_b  <= wr_data[BIT_WSW];
                    end
                end
            endcase
        end
    end

    // Assemble the read view; unused bits are zero.
    always_comb begin
        status           = '0;
        status[BIT_BOR]  = bor_f;
        status[BIT_POR]  = por_f;
        status[BIT_FAST] = fast_b;
        status[BIT_WSW]  = wsw_b;
    end
endmodule

// File: rtl/rst_delay_seq.sv
// Start-up delay sequencer. On a cause it picks the delay phases:
// power-up timer (slow ticks) for power/brown-out when enabled, then the
// oscillator settle count (main clock) in crystal mode. Holds the core
// until the phases are done. A new cause restarts the sequence.
module rst_delay_seq
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024
) (
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t cause,
    input  logic   slow_tick,
    input  logic   xtal_mode,
    input  logic   pwrt_en,
    output logic   core_hold
);
    localparam int PW = (PWRT_TICKS > 1) ? $clog2(PWRT_TICKS) : 1;
    localparam int OW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [PW-1:0] P_LIM = PW'(PWRT_TICKS - 1);
    localparam logic [OW-1:0] O_LIM = OW'(OST_CYCLES - 1);

    seq_state_t state, nxt;
    logic launch, is_pow, use_pwrt, use_ost, pwrt_done, ost_done;

    // Decide whether a sequence starts and which phases it needs.
    always_comb begin
        launch   = (cause != CZ_NONE) || (state == SQ_START);
        is_pow   = (state == SQ_START) || (cause == CZ_POR) || (cause == CZ_BOR);
        use_pwrt = is_pow && pwrt_en;
        use_ost  = xtal_mode;
    end

    rst_span_counter #(.W(PW)) u_pwrt_cnt (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .inc((state == SQ_PWRT) && slow_tick), .limit(P_LIM), .done(pwrt_done)
    );

    rst_span_counter #(.W(OW)) u_ost_cnt (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .inc(state == SQ_OST), .limit(O_LIM), .done(ost_done)
    );

    // Next-state selection.
    always_comb begin
        nxt = state;
        if (launch)
            nxt = use_pwrt ? SQ_PWRT : (use_ost ? SQ_OST : SQ_RUN);
        else if (state == SQ_PWRT && pwrt_done)
            nxt = xtal_mode ? SQ_OST : SQ_RUN;
        else if (state == SQ_OST && ost_done)
            nxt = SQ_RUN;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_START;
        else        state <= nxt;
    end

    assign core_hold = (state != SQ_RUN);
endmodule

// File: rtl/rst_cause_sequencer.sv
// Top: reset cause tracking and start-up delay sequencing.
// Assumes all event inputs and slow_tick are synchronous to clk.
module rst_cause_sequencer
    import rst_seq_pkg::*;
#(
    parameter int REG_W      = 8,
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             por_evt,
    input  logic             bor_evt,
    input  logic             bod_en,
    input  logic             wdt_evt,
    input  logic             wake_evt,
    input  logic             xtal_mode,
    input  logic             pwrt_en,
    input  logic             wdt_fuse,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] status,
    output logic             core_hold,
    output logic             osc_fast,
    output logic             wdt_run
);
    cause_t cause;

    rst_cause_arb u_arb (
        .por_evt(por_evt), .bor_evt(bor_evt), .bod_en(bod_en),
        .wdt_evt(wdt_evt), .wake_evt(wake_evt), .core_hold(core_hold),
        .cause(cause)
    );

    rst_status_reg #(.REG_W(REG_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .cause(cause),
        .wr_en(wr_en), .wr_data(wr_data), .status(status)
    );

    rst_delay_seq #(.PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cause(cause), .slow_tick(slow_tick),
        .xtal_mode(xtal_mode), .pwrt_en(pwrt_en), .core_hold(core_hold)
    );

    // Control outputs derived from the register.
    assign osc_fast = status[BIT_FAST];
    assign wdt_run  = wdt_fuse | status[BIT_WSW];
endmodule

// File: rtl/rst_cause_sequencer_chk.sv
// Property checker for the reset cause sequencer, bound to the top.
module rst_cause_sequencer_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_evt,
    input logic             bor_evt,
    input logic             bod_en,
    input logic             wdt_evt,
    input logic             wake_evt,
    input logic             xtal_mode,
    input logic [REG_W-1:0] status,
    input logic             core_hold
);
    assert_por_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> (status[1:0] == 2'b01) && (status[4:3] == 2'b01));

    assert_bor_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bor_evt && bod_en && !por_evt) |=> (!status[0] && status[1] == $past(status[1])));

    assert_wdt_keeps_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_evt && !por_evt && !(bor_evt && bod_en)) |=> (status[1:0] == $past(status[1:0])));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] == 1'b0) && (status[7:5] == 3'b000));

    assert_nonxtal_wake_nohold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && !core_hold && !xtal_mode && !por_evt && !(bor_evt && bod_en) && !wdt_evt)
        |=> !core_hold);
endmodule

bind rst_cause_sequencer rst_cause_sequencer_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bor_evt(bor_evt),
    .bod_en(bod_en), .wdt_evt(wdt_evt), .wake_evt(wake_evt),
    .xtal_mode(xtal_mode), .status(status), .core_hold(core_hold)
);

// File: tb/rst_cause_sequencer_test.sv
// Sweeps causes against oscillator mode and timer enable; delay lengths are
// computed from the tick phase and the parameters.
module rst_cause_sequencer_test;
    localparam int PT = 3;   // power-up ticks
    localparam int OC = 8;   // settle cycles
    localparam int TP = 4;   // slow tick period in clocks

    logic clk = 0, rst_n = 0;
    logic por_evt = 0, bor_evt = 0, bod_en = 1, wdt_evt = 0, wake_evt = 0;
    logic xtal_mode = 1, pwrt_en = 1, wdt_fuse = 0, wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] status;
    logic core_hold, osc_fast, wdt_run, slow_tick;
    int tphase = 0, ph0 = 0, errors = 0, checks = 0, cyc = 0;

    rst_cause_sequencer #(.REG_W(8), .PWRT_TICKS(PT), .OST_CYCLES(OC)) uut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .por_evt(por_evt),
        .bor_evt(bor_evt), .bod_en(bod_en), .wdt_evt(wdt_evt), .wake_evt(wake_evt),
        .xtal_mode(xtal_mode), .pwrt_en(pwrt_en), .wdt_fuse(wdt_fuse),
        .wr_en(wr_en), .wr_data(wr_data), .status(status), .core_hold(core_hold),
        .osc_fast(osc_fast), .wdt_run(wdt_run)
    );

    always #5 clk = ~clk;
    assign slow_tick = (tphase == 0);
    always @(negedge clk) tphase <= (tphase + 1) % TP;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // mask: bit0 power-on, bit1 brown-out, bit2 watchdog, bit3 wake
    task automatic pulse(int mask);
        @(negedge clk); #1;
        ph0 = tphase;
        por_evt = mask[0]; bor_evt = mask[1]; wdt_evt = mask[2]; wake_evt = mask[3];
        @(negedge clk); #1;
        por_evt = 0; bor_evt = 0; wdt_evt = 0; wake_evt = 0;
    endtask

    task automatic hold_len(output int n);
        n = 0;
        while (core_hold && n < 5000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic wr(int d);
        @(negedge clk); #1;
        wr_en = 1; wr_data = 8'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    function automatic int exp_len(int c, int x, int pe);
        int f, p;
        bit pow = (c == 0) || (c == 1);
        f = (TP - ph0) % TP;
        if (f == 0) f = TP;
        p = (pow && pe != 0) ? f + (PT - 1) * TP : 0;
        return p + ((x != 0) ? OC : 0);
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        #1;
        check("R1 reset status", status, 8'h09);
        check("R5 osc_fast after reset", osc_fast, 1);
        check("R5 wdt_run fuse off", wdt_run, 0);
        hold_len(n);

        // R4/R5 register writes
        wr(8'hFF);
        check("R4 write ones, reserved zero", status, 8'h1B);
        check("R5 osc_fast high", osc_fast, 1);
        check("R5 wdt_run from bit4", wdt_run, 1);
        wr(8'h00);
        check("R4 write zeros", status, 8'h00);
        check("R5 osc_fast low-power", osc_fast, 0);
        check("R5 wdt_run off", wdt_run, 0);
        wdt_fuse = 1; #1;
        check("R5 wdt_run from fuse", wdt_run, 1);
        wdt_fuse = 0;

        // R6 R7 R8 R9 sweep of cause x mode x timer enable
        for (int x = 0; x < 2; x++)
            for (int pe = 0; pe < 2; pe++)
                for (int c = 0; c < 4; c++) begin
                    xtal_mode = x[0]; pwrt_en = pe[0];
                    pulse(1 << c);
                    hold_len(n);
                    check($sformatf("R6/R7/R8 R9 delay cause=%0d x=%0d pe=%0d", c, x, pe),
                          n, exp_len(c, x, pe));
                    repeat (2) @(negedge clk);
                end

        // R2 brown-out flags
        wr(8'h13);
        pulse(2); hold_len(n);
        check("R2 brown-out flags", status, 8'h0A);
        wr(8'h13);
        bod_en = 0;
        pulse(2); #1;
        check("R2 ignored brown-out register", status, 8'h13);
        check("R2 ignored brown-out hold", core_hold, 0);
        bod_en = 1;

        // R3 watchdog and wake register effects
        wr(8'h12);
        xtal_mode = 0;
        pulse(4); hold_len(n);
        check("R3 watchdog keeps flags", status, 8'h0A);
        wr(8'h13);
        pulse(8); hold_len(n);
        check("R3 wake leaves register", status, 8'h13);

        // R4 reset event beats a same-cycle write
        @(negedge clk); #1;
        wr_en = 1; wr_data = 8'h00; por_evt = 1;
        @(negedge clk); #1;
        wr_en = 0; por_evt = 0;
        check("R4 power-on beats write", status, 8'h09);
        hold_len(n);

        // R9 priority: power-on with watchdog, non-crystal, timer on
        xtal_mode = 0; pwrt_en = 1;
        pulse(5); hold_len(n);
        check("R9 power-on wins over watchdog", n, exp_len(0, 0, 1));

        // R8 wake ignored during hold; R9 restart by watchdog
        xtal_mode = 1; pwrt_en = 0;
        pulse(1);
        @(negedge clk); #1;
        pulse(8); hold_len(n);
        check("R8 wake ignored while held", n, OC - 3);
        pulse(1);
        @(negedge clk); #1;
        pulse(4); hold_len(n);
        check("R9 watchdog restarts delay", n, OC);

        summary();
    end
endmodule